// File: doc/BRIEF.md
# Auto-Indexed Decoder Register Window

This block is the host-facing register window of a CD data decoder. The host first loads a 4-bit register index. It then moves single bytes in or out with a read strobe or a write strobe. For most registers the index steps forward by one after each access. A burst of strobes therefore walks through neighbouring registers without reloading the index. Some registers are laid out differently for reads and for writes, so the same index can reach a different register depending on direction.

Besides plain storage, the window produces the control side effects of the decoder interface:
- It starts and stops host transfers, and reports a one-cycle start pulse to the transfer engine.
- It tracks an interface status byte whose flag bits are active-low.
- It re-arms the last status byte only after software has read a fixed set of decoder registers.
- It provides a soft reset that matches a synchronous clear input exactly.

Two inputs from neighbouring blocks feed this window. The transfer engine reports the end of a transfer, and the decoder reports that a decoded sector is ready.

Top module: `cdc_reg_window`

## Requirements
- R1: After reset the registers read back as follows:
  - index 0 reads 0x00 and index 1 reads 0xFF.
  - Indices 2 to 6 read 0x00, index 7 reads 0x01, and indices 8 and 9 read 0x00.
  - Index 0xA reads 0x60, index 0xB reads 0x12, and index 0xC reads 0x80.
  - Indices 0xD to 0xF read 0x00.
  - The index is 0, no transfer is active, and the byte-count, data-address, control, interface-control and status-out outputs are all zero.
- R2: Reads map indices to registers as follows:
  - 0 is the command input and 1 is the interface status.
  - 2 and 3 are the byte count, low byte then high byte.
  - 4 to 7 are header bytes 0 to 3.
  - 8 and 9 are the pointer, low then high.
  - 0xA and 0xB are the write address, low then high.
  - 0xC to 0xF are status bytes 0 to 3.
  - `rd_data_o` always shows the register selected by the current index.
- R3: Writes map indices to registers as follows:
  - 0 is status-out and 1 is interface control.
  - 2 and 3 are the byte count, low then high.
  - 4 and 5 are the data address, low then high.
  - 6 is the transfer trigger and 7 is the transfer acknowledge.
  - 8 and 9 are the write address, low then high.
  - 0xA and 0xB are control bytes 0 and 1.
  - 0xC and 0xD are the pointer, low then high.
  - 0xE is control byte 2 and 0xF is soft reset.
- R4: A read at any index from 0 to 0xE advances the index by one. A write at indices 0 to 5 or 8 to 0xD also advances it by one.
- R5: The index does not move after a read at 0xF, or after a write at 6, 7, 0xE or 0xF.
- R6: Writing interface control with bit 1 clear stops any transfer. The byte count goes to zero, the transfer goes inactive and interface status bit 3 goes to 1.
- R7: Writing the trigger while interface control bit 1 is 1 starts a transfer:
  - Interface status bit 3 clears.
  - The transfer goes active.
  - `xfer_start_o` is high for exactly the cycle after the write.
  - With bit 1 clear, the trigger does nothing.
- R8: Writing the acknowledge register sets interface status bit 6.
- R9: A `xfer_done_i` pulse ends the transfer. The transfer goes inactive and status bit 3 goes to 1. Status bit 6 is cleared only if interface control bit 6 is 1. A `dec_ready_i` pulse clears status bit 5.
- R10: A read at index 0xF returns the old value of status byte 3 and sets interface status bit 5. If control 0 bit 7 and interface control bit 5 are both 1, and every index in mask 0x73F2 has been read since reset, that read also loads status byte 3 with 0x80.
- R11: A write at index 0xF and a `clr_i` pulse both return all registers and the read-tracking mask to the R1 values. Neither moves the index, and both produce a one-cycle `soft_rst_o` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_i | input | 1 | Synchronous register clear, same effect as a soft reset |
| addr_ld_i | input | 1 | Load the register index from addr_i; strobes in that cycle are ignored |
| addr_i | input | 4 | Register index to load |
| rd_stb_i | input | 1 | Read strobe; ignored when wr_stb_i is also high |
| wr_stb_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| xfer_done_i | input | 1 | End-of-transfer pulse from the transfer engine |
| dec_ready_i | input | 1 | Sector-decoded pulse from the decoder |
| rd_data_o | output | 8 | Byte of the register selected by the index |
| addr_o | output | 4 | Current register index |
| xfer_active_o | output | 1 | Host transfer in progress |
| xfer_start_o | output | 1 | One-cycle pulse after a qualified trigger |
| soft_rst_o | output | 1 | One-cycle pulse after a soft reset or clear |
| ifctrl_o | output | 8 | Interface control register |
| sbout_o | output | 8 | Status-out register |
| ctrl_o | output | 24 | Control bytes 2, 1, 0 (byte 0 in the low bits) |
| dbc_o | output | 16 | Byte count |
| dac_o | output | 16 | Data address |

## Verification
A corrupted index shows up on the very next read: `rd_data_o` returns a neighbouring register's byte, and `addr_o` drifts away from the count of strobes since the last load. A wrong interface status or transfer flag can be seen one cycle after the side-effect strobe, through `xfer_active_o`, `dbc_o` or an index-1 read. A lost read-tracking bit stays hidden until software reads index 0xF twice: the second read then fails to return 0x80.

// File: rtl/cdc_win_pkg.sv
package cdc_win_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned NREG   = 1 << ADDR_W;

  // Read-side register selection.
  typedef enum logic [ADDR_W-1:0] {
    RD_CMDIN  = 4'h0, RD_IFSTAT = 4'h1, RD_CNT_LO = 4'h2, RD_CNT_HI = 4'h3,
    RD_HDR0   = 4'h4, RD_HDR1   = 4'h5, RD_HDR2   = 4'h6, RD_HDR3   = 4'h7,
    RD_PTR_LO = 4'h8, RD_PTR_HI = 4'h9, RD_WA_LO  = 4'hA, RD_WA_HI  = 4'hB,
    RD_ST0    = 4'hC, RD_ST1    = 4'hD, RD_ST2    = 4'hE, RD_ST3    = 4'hF
  } rd_sel_e;

  // Write-side register selection.
  typedef enum logic [ADDR_W-1:0] {
    WR_SBOUT  = 4'h0, WR_IFCTRL = 4'h1, WR_CNT_LO = 4'h2, WR_CNT_HI = 4'h3,
    WR_DA_LO  = 4'h4, WR_DA_HI  = 4'h5, WR_TRIG   = 4'h6, WR_ACK    = 4'h7,
    WR_WA_LO  = 4'h8, WR_WA_HI  = 4'h9, WR_CTL0   = 4'hA, WR_CTL1   = 4'hB,
    WR_PTR_LO = 4'hC, WR_PTR_HI = 4'hD, WR_CTL2   = 4'hE, WR_SRST   = 4'hF
  } wr_sel_e;

  // Interface status flag bits (active low).
  localparam int unsigned IFS_XFER_IDLE = 3;
  localparam int unsigned IFS_DEC_IDLE  = 5;
  localparam int unsigned IFS_DTE_IDLE  = 6;

  // Interface control bits.
  localparam int unsigned IFC_XFER_EN = 1;
  localparam int unsigned IFC_DEC_IE  = 5;
  localparam int unsigned IFC_DTE_IE  = 6;

  // Control byte 0 bit.
  localparam int unsigned CTL0_DEC_EN = 7;

  localparam logic [BYTE_W-1:0]   IFSTAT_RST = 8'hFF;
  localparam logic [4*BYTE_W-1:0] HDR_RST    = 32'h0100_0000;
  localparam logic [WORD_W-1:0]   WA_RST     = 16'd4704;
  localparam logic [4*BYTE_W-1:0] STAT_RST   = 32'h0000_0080;
  localparam logic [BYTE_W-1:0]   STAT3_ARM  = 8'h80;
  localparam logic [NREG-1:0]     TRACK_MASK = 16'h73F2;

  typedef struct packed {
    logic [BYTE_W-1:0]      cmdin;
    logic [BYTE_W-1:0]      ifstat;
    logic [BYTE_W-1:0]      ifctrl;
    logic [BYTE_W-1:0]      sbout;
    logic [BYTE_W-1:0]      ctl0;
    logic [BYTE_W-1:0]      ctl1;
    logic [BYTE_W-1:0]      ctl2;
    logic [WORD_W-1:0]      dbc;
    logic [WORD_W-1:0]      dac;
    logic [WORD_W-1:0]      wa;
    logic [WORD_W-1:0]      pt;
    logic [3:0][BYTE_W-1:0] hdr;
    logic [3:0][BYTE_W-1:0] stat;
    logic                   active;
  } win_regs_t;

  // Single source of the reset image, shared by hard and soft reset.
  function automatic win_regs_t win_reset();
    win_regs_t r;
    r        = '0;
    r.ifstat = IFSTAT_RST;
    r.hdr    = HDR_RST;
    r.wa     = WA_RST;
    r.stat   = STAT_RST;
    return r;
  endfunction

endpackage

// File: rtl/cdc_addr_seq.sv
module cdc_addr_seq
  import cdc_win_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          rd_go_i,
  input  logic          wr_go_i,
  output logic [AW-1:0] addr_o
);

  localparam logic [AW-1:0] LAST_IDX = '1;

  logic [AW-1:0] addr_q, addr_d;
  logic          wr_hold, adv, en;

  always_comb begin
    wr_hold = (wr_sel_e'(addr_q) == WR_TRIG) || (wr_sel_e'(addr_q) == WR_ACK) ||
              (wr_sel_e'(addr_q) == WR_CTL2) || (wr_sel_e'(addr_q) == WR_SRST);
    adv     = (rd_go_i && (addr_q != LAST_IDX)) || (wr_go_i && !wr_hold);
    en      = ld_i || adv;
    addr_d  = ld_i ? ld_addr_i : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (en) begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/cdc_read_track.sv
module cdc_read_track
  import cdc_win_pkg::*;
#(
  parameter int unsigned   N    = NREG,
  parameter logic [N-1:0]  MASK = TRACK_MASK,
  localparam int unsigned  AW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rd_go_i,
  input  logic [AW-1:0] addr_i,
  output logic          all_seen_o
);

  logic [N-1:0] seen;

  for (genvar i = 0; i < N; i++) begin : g_idx
    if (MASK[i]) begin : g_trk
      logic seen_q, seen_d;

      always_comb begin
        seen_d = seen_q;
        if (rd_go_i && (addr_i == AW'(i))) seen_d = 1'b1;
        if (clr_i) seen_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          seen_q <= 1'b0;
        end else if (clr_i || rd_go_i) begin
          seen_q <= seen_d;
        end
      end

      assign seen[i] = seen_q;
    end else begin : g_none
      assign seen[i] = 1'b0;
    end
  end

  assign all_seen_o = &(seen | ~MASK);

endmodule

// File: rtl/cdc_reg_bank.sv
module cdc_reg_bank
  import cdc_win_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rd_go_i,
  input  logic          wr_go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          xfer_done_i,
  input  logic          dec_ready_i,
  input  logic          all_seen_i,
  output win_regs_t     regs_o,
  output logic          start_o,
  output logic          srst_o
);

  win_regs_t r_q, r_d;
  logic      start_q, start_d;
  logic      srst_q;
  logic      en;

  always_comb begin
    r_d     = r_q;
    start_d = 1'b0;

    // Neighbour events first; host strobes applied afterwards take priority.
    if (xfer_done_i) begin
      r_d.ifstat[IFS_XFER_IDLE] = 1'b1;
      r_d.active                = 1'b0;
      if (r_q.ifctrl[IFC_DTE_IE]) r_d.ifstat[IFS_DTE_IDLE] = 1'b0;
    end
    if (dec_ready_i) r_d.ifstat[IFS_DEC_IDLE] = 1'b0;

    if (rd_go_i && (rd_sel_e'(addr_i) == RD_ST3)) begin
      r_d.ifstat[IFS_DEC_IDLE] = 1'b1;
      if (r_q.ctl0[CTL0_DEC_EN] && r_q.ifctrl[IFC_DEC_IE] && all_seen_i)
        r_d.stat[3] = STAT3_ARM;
    end

    if (wr_go_i) begin
      case (wr_sel_e'(addr_i))
        WR_SBOUT:  r_d.sbout = wr_data_i;
        WR_IFCTRL: begin
          r_d.ifctrl = wr_data_i;
          if (!wr_data_i[IFC_XFER_EN]) begin
            r_d.dbc                   = '0;
            r_d.active                = 1'b0;
            r_d.ifstat[IFS_XFER_IDLE] = 1'b1;
          end
        end
        WR_CNT_LO: r_d.dbc[DW-1:0]    = wr_data_i;
        WR_CNT_HI: r_d.dbc[2*DW-1:DW] = wr_data_i;
        WR_DA_LO:  r_d.dac[DW-1:0]    = wr_data_i;
        WR_DA_HI:  r_d.dac[2*DW-1:DW] = wr_data_i;
        WR_TRIG: begin
          if (r_q.ifctrl[IFC_XFER_EN]) begin
            r_d.ifstat[IFS_XFER_IDLE] = 1'b0;
            r_d.active                = 1'b1;
            start_d                   = 1'b1;
          end
        end
        WR_ACK:    r_d.ifstat[IFS_DTE_IDLE] = 1'b1;
        WR_WA_LO:  r_d.wa[DW-1:0]    = wr_data_i;
        WR_WA_HI:  r_d.wa[2*DW-1:DW] = wr_data_i;
        WR_CTL0:   r_d.ctl0 = wr_data_i;
        WR_CTL1:   r_d.ctl1 = wr_data_i;
        WR_PTR_LO: r_d.pt[DW-1:0]    = wr_data_i;
        WR_PTR_HI: r_d.pt[2*DW-1:DW] = wr_data_i;
        WR_CTL2:   r_d.ctl2 = wr_data_i;
        default:   ;
      endcase
    end

    if (clr_i) begin
      r_d     = win_reset();
      start_d = 1'b0;
    end
  end

  assign en = clr_i || rd_go_i || wr_go_i || xfer_done_i || dec_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q     <= win_reset();
      start_q <= 1'b0;
      srst_q  <= 1'b0;
    end else begin
      if (en) r_q <= r_d;
      start_q <= start_d;
      srst_q  <= clr_i;
    end
  end

  assign regs_o  = r_q;
  assign start_o = start_q;
  assign srst_o  = srst_q;

endmodule

// File: rtl/cdc_read_mux.sv
module cdc_read_mux
  import cdc_win_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = BYTE_W
) (
  input  win_regs_t     regs_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] rd_data_o
);

  always_comb begin
    case (rd_sel_e'(addr_i))
      RD_CMDIN:  rd_data_o = regs_i.cmdin;
      RD_IFSTAT: rd_data_o = regs_i.ifstat;
      RD_CNT_LO: rd_data_o = regs_i.dbc[DW-1:0];
      RD_CNT_HI: rd_data_o = regs_i.dbc[2*DW-1:DW];
      RD_HDR0:   rd_data_o = regs_i.hdr[0];
      RD_HDR1:   rd_data_o = regs_i.hdr[1];
      RD_HDR2:   rd_data_o = regs_i.hdr[2];
      RD_HDR3:   rd_data_o = regs_i.hdr[3];
      RD_PTR_LO: rd_data_o = regs_i.pt[DW-1:0];
      RD_PTR_HI: rd_data_o = regs_i.pt[2*DW-1:DW];
      RD_WA_LO:  rd_data_o = regs_i.wa[DW-1:0];
      RD_WA_HI:  rd_data_o = regs_i.wa[2*DW-1:DW];
      RD_ST0:    rd_data_o = regs_i.stat[0];
      RD_ST1:    rd_data_o = regs_i.stat[1];
      RD_ST2:    rd_data_o = regs_i.stat[2];
      RD_ST3:    rd_data_o = regs_i.stat[3];
      default:   rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/cdc_reg_window.sv
module cdc_reg_window
  import cdc_win_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                addr_ld_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rd_stb_i,
  input  logic                wr_stb_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  input  logic                xfer_done_i,
  input  logic                dec_ready_i,
  output logic [BYTE_W-1:0]   rd_data_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                xfer_active_o,
  output logic                xfer_start_o,
  output logic                soft_rst_o,
  output logic [BYTE_W-1:0]   ifctrl_o,
  output logic [BYTE_W-1:0]   sbout_o,
  output logic [3*BYTE_W-1:0] ctrl_o,
  output logic [WORD_W-1:0]   dbc_o,
  output logic [WORD_W-1:0]   dac_o
);

  // Reset synchronizer: asserts at once, releases on the clock.
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[RST_STAGES-1];

  logic              rd_go, wr_go, soft_clr, all_seen;
  logic [ADDR_W-1:0] addr_q;
  win_regs_t         regs;

  // Index load masks both strobes; a write masks a read.
  assign rd_go    = rd_stb_i && !wr_stb_i && !addr_ld_i;
  assign wr_go    = wr_stb_i && !addr_ld_i;
  assign soft_clr = clr_i || (wr_go && (wr_sel_e'(addr_q) == WR_SRST));

  cdc_addr_seq #(.AW(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ld_i      (addr_ld_i),
    .ld_addr_i (addr_i),
    .rd_go_i   (rd_go),
    .wr_go_i   (wr_go),
    .addr_o    (addr_q)
  );

  cdc_read_track #(.N(NREG), .MASK(TRACK_MASK)) u_track (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clr_i      (soft_clr),
    .rd_go_i    (rd_go),
    .addr_i     (addr_q),
    .all_seen_o (all_seen)
  );

  cdc_reg_bank #(.AW(ADDR_W), .DW(BYTE_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .clr_i       (soft_clr),
    .rd_go_i     (rd_go),
    .wr_go_i     (wr_go),
    .addr_i      (addr_q),
    .wr_data_i   (wr_data_i),
    .xfer_done_i (xfer_done_i),
    .dec_ready_i (dec_ready_i),
    .all_seen_i  (all_seen),
    .regs_o      (regs),
    .start_o     (xfer_start_o),
    .srst_o      (soft_rst_o)
  );

  cdc_read_mux #(.AW(ADDR_W), .DW(BYTE_W)) u_rmux (
    .regs_i    (regs),
    .addr_i    (addr_q),
    .rd_data_o (rd_data_o)
  );

  assign addr_o        = addr_q;
  assign xfer_active_o = regs.active;
  assign ifctrl_o      = regs.ifctrl;
  assign sbout_o       = regs.sbout;
  assign ctrl_o        = {regs.ctl2, regs.ctl1, regs.ctl0};
  assign dbc_o         = regs.dbc;
  assign dac_o         = regs.dac;

endmodule

// File: rtl/cdc_reg_window_chk.sv
module cdc_reg_window_chk (
  input logic        clk,
  input logic        rst_ni,
  input logic        clr_i,
  input logic        addr_ld_i,
  input logic        rd_stb_i,
  input logic        wr_stb_i,
  input logic        wr_xfer_en_i,
  input logic        ifctrl_en_i,
  input logic [3:0]  addr_o,
  input logic        xfer_active_o,
  input logic        xfer_start_o,
  input logic        soft_rst_o,
  input logic [15:0] dbc_o
);

  AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_stb_i && !wr_stb_i && !addr_ld_i && addr_o != 4'hF) |=> (addr_o == $past(addr_o) + 4'd1)); // R4

  AST_STAT3_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_stb_i && !wr_stb_i && !addr_ld_i && addr_o == 4'hF) |=> (addr_o == 4'hF)); // R5

  AST_WR_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_stb_i && !addr_ld_i && (addr_o == 4'h6 || addr_o == 4'h7 || addr_o == 4'hE || addr_o == 4'hF))
      |=> $stable(addr_o)); // R5

  AST_STOP_XFER: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_stb_i && !addr_ld_i && addr_o == 4'h1 && !wr_xfer_en_i) |=> (!xfer_active_o && dbc_o == 16'h0)); // R6

  AST_START_QUAL: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer_start_o |-> (xfer_active_o && $past(wr_stb_i && !addr_ld_i && addr_o == 4'h6 && ifctrl_en_i))); // R7

  AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_i || (wr_stb_i && !addr_ld_i && addr_o == 4'hF)) |=> (soft_rst_o && dbc_o == 16'h0 && !xfer_active_o)); // R11

endmodule

bind cdc_reg_window cdc_reg_window_chk u_chk (
  .clk           (clk),
  .rst_ni        (rst_n_int),
  .clr_i         (clr_i),
  .addr_ld_i     (addr_ld_i),
  .rd_stb_i      (rd_stb_i),
  .wr_stb_i      (wr_stb_i),
  .wr_xfer_en_i  (wr_data_i[1]),
  .ifctrl_en_i   (ifctrl_o[1]),
  .addr_o        (addr_o),
  .xfer_active_o (xfer_active_o),
  .xfer_start_o  (xfer_start_o),
  .soft_rst_o    (soft_rst_o),
  .dbc_o         (dbc_o)
);

// File: tb/cdc_reg_window_tb.sv
module cdc_reg_window_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        addr_ld = 1'b0;
  logic [3:0]  addr_in = 4'h0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        xfer_done = 1'b0;
  logic        dec_ready = 1'b0;
  logic [7:0]  rd_data;
  logic [3:0]  addr_o;
  logic        active, start, srst;
  logic [7:0]  ifctrl, sbout;
  logic [23:0] ctrl;
  logic [15:0] dbc, dac;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit          done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  cdc_reg_window dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .addr_ld_i(addr_ld), .addr_i(addr_in),
    .rd_stb_i(rd_stb), .wr_stb_i(wr_stb), .wr_data_i(wr_data),
    .xfer_done_i(xfer_done), .dec_ready_i(dec_ready),
    .rd_data_o(rd_data), .addr_o(addr_o), .xfer_active_o(active),
    .xfer_start_o(start), .soft_rst_o(srst), .ifctrl_o(ifctrl), .sbout_o(sbout),
    .ctrl_o(ctrl), .dbc_o(dbc), .dac_o(dac)
  );

  // Scoreboard monitor: compares each qualified read against the queue.
  always @(negedge clk) begin
    #5;
    if (rd_stb && !wr_stb && !addr_ld) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected read: act=%02h exp=none", rd_data);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: act=%02h exp=%02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(input logic [3:0] a);
    addr_ld = 1'b1; addr_in = a;
    @(negedge clk);
    addr_ld = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic pulse_dec();
    dec_ready = 1'b1;
    @(negedge clk);
    dec_ready = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    chk("R1 index", addr_o, 4'h0);
    chk("R1 active", active, 1'b0);
    chk("R1 dbc", dbc, 16'h0);
    chk("R1 dac", dac, 16'h0);
    chk("R1 ifctrl", ifctrl, 8'h00);
    chk("R1 ctrl", ctrl, 24'h0);
    chk("R1 sbout", sbout, 8'h00);

    // R1/R2 reset values through a read burst, R4 auto-advance
    load(4'h0);
    rd(8'h00, "R1 cmdin");  rd(8'hFF, "R1 ifstat"); rd(8'h00, "R1 cnt lo");
    rd(8'h00, "R1 cnt hi"); rd(8'h00, "R1 hdr0");   rd(8'h00, "R1 hdr1");
    rd(8'h00, "R1 hdr2");   rd(8'h01, "R1 hdr3");   rd(8'h00, "R1 ptr lo");
    chk("R4 index after 9 reads", addr_o, 4'h9);
    load(4'hC);
    rd(8'h80, "R1 st0"); rd(8'h00, "R1 st1"); rd(8'h00, "R1 st2");
    chk("R4 index reaches F", addr_o, 4'hF);
    rd(8'h00, "R1 st3");
    chk("R5 read F holds index", addr_o, 4'hF);

    // R10 arming conditions, tracking mask still missing index 9
    load(4'h1); wr(8'h20);
    load(4'hA); wr(8'h80);
    chk("R4 write advances", addr_o, 4'hB);
    chk("R3 ctl0 write", ctrl, 24'h000080);
    load(4'hF);
    rd(8'h00, "R10 st3 no reload, mask incomplete");
    rd(8'h00, "R10 st3 still clear");
    load(4'h9); rd(8'h00, "R1 ptr hi");
    load(4'hF);
    rd(8'h00, "R10 st3 old value on arming read");
    rd(8'h80, "R10 st3 reloaded");

    // R9 decoder-ready clears bit 5; R10 read F sets it again
    pulse_dec();
    load(4'h1); rd(8'hDF, "R9 dec ready clears bit5");
    load(4'hF); rd(8'h80, "R10 st3 read");
    load(4'h1); rd(8'hFF, "R10 read F sets bit5");

    // R3 write map differs from read map
    load(4'h8); wr(8'hAB); wr(8'hCD);
    chk("R4 index after wa writes", addr_o, 4'hA);
    rd(8'hAB, "R3 wa lo via read A"); rd(8'hCD, "R3 wa hi via read B");
    load(4'hC); wr(8'h11); wr(8'h22);
    chk("R4 index after ptr writes", addr_o, 4'hE);
    wr(8'h55);
    chk("R5 ctl2 write holds index", addr_o, 4'hE);
    chk("R3 ctl2 write", ctrl, 24'h550080);
    load(4'h8); rd(8'h11, "R3 ptr lo via read 8"); rd(8'h22, "R3 ptr hi via read 9");

    load(4'h0);
    wr(8'h5A); wr(8'h02); wr(8'h34); wr(8'h12); wr(8'h78); wr(8'h56);
    chk("R3 sbout", sbout, 8'h5A);
    chk("R3 ifctrl", ifctrl, 8'h02);
    chk("R3 dbc", dbc, 16'h1234);
    chk("R3 dac", dac, 16'h5678);
    chk("R4 index after 6 writes", addr_o, 4'h6);

    // R7 qualified trigger
    wr(8'h00);
    chk("R7 start pulse", start, 1'b1);
    chk("R7 active", active, 1'b1);
    chk("R5 trigger holds index", addr_o, 4'h6);
    tick();
    chk("R7 start one cycle", start, 1'b0);
    load(4'h1); rd(8'hF7, "R7 bit3 cleared");
    rd(8'h34, "R2 cnt lo"); rd(8'h12, "R2 cnt hi");

    // R6 stop
    load(4'h1); wr(8'h00);
    chk("R6 active cleared", active, 1'b0);
    chk("R6 dbc zeroed", dbc, 16'h0);
    load(4'h1); rd(8'hFF, "R6 bit3 set");

    // R7 trigger ignored when disabled
    load(4'h6); wr(8'h00);
    chk("R7 no start when disabled", start, 1'b0);
    chk("R7 stays idle", active, 1'b0);
    load(4'h1); rd(8'hFF, "R7 ifstat unchanged");

    // R9 done with interrupt enable, then R8 acknowledge
    load(4'h1); wr(8'h42);
    load(4'h6); wr(8'h00);
    chk("R7 active again", active, 1'b1);
    pulse_done();
    chk("R9 done clears active", active, 1'b0);
    load(4'h1); rd(8'hBF, "R9 done sets bit3 clears bit6");
    load(4'h7); wr(8'h00);
    chk("R5 ack holds index", addr_o, 4'h7);
    load(4'h1); rd(8'hFF, "R8 ack sets bit6");

    // R9 done without interrupt enable
    load(4'h1); wr(8'h02);
    load(4'h6); wr(8'h00);
    pulse_done();
    chk("R9 done clears active (no ie)", active, 1'b0);
    load(4'h1); rd(8'hFF, "R9 bit6 kept without enable");

    // R11 soft reset write
    load(4'h2); wr(8'h99);
    chk("R3 cnt lo write", dbc, 16'h0099);
    load(4'hF); wr(8'h00);
    chk("R11 soft reset pulse", srst, 1'b1);
    chk("R5 reset write holds index", addr_o, 4'hF);
    chk("R11 dbc cleared", dbc, 16'h0);
    chk("R11 ifctrl cleared", ifctrl, 8'h00);
    chk("R11 ctrl cleared", ctrl, 24'h0);
    rd(8'h00, "R11 st3 back to reset");
    load(4'hA); rd(8'h60, "R11 wa lo"); rd(8'h12, "R11 wa hi");
    load(4'h7); rd(8'h01, "R11 hdr3");

    // R11 synchronous clear input
    load(4'h2); wr(8'h77); wr(8'h66);
    chk("R3 dbc before clear", dbc, 16'h6677);
    pulse_clr();
    chk("R11 clr pulse", srst, 1'b1);
    chk("R11 clr dbc", dbc, 16'h0);
    chk("R11 clr holds index", addr_o, 4'h4);
    load(4'hA); rd(8'h60, "R11 clr wa lo"); rd(8'h12, "R11 clr wa hi");
    load(4'hC); rd(8'h80, "R11 clr st0");

    tick();
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2 pending reads: act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule